// File: doc/BRIEF.md
# Windowed-Sinc Low-Pass Coefficient Generator

This unit produces the tap weights of a linear-phase low-pass FIR filter by arithmetic, so that no coefficient memory is needed. After a start pulse it captures a normalized cutoff, a filter order N (up to 63, so up to 64 taps) and a window code. For every tap index n from 0 to N it evaluates the ideal response shifted to the filter centre, h = sin(pi*fc*m)/(pi*m) with m = n - N/2, and scales it by the chosen taper. It emits one signed Q1.15 weight per tap with its index and a one-cycle strobe.

Sine and cosine come from a seventh-order odd polynomial, applied after the angle is folded into [-pi/2, pi/2]. All divisions (by pi*m for the response, and by the window denominators) go through one shared restoring divider that yields one quotient bit per cycle. The fixed iteration count gives every tap the same cycle budget.

The controller has seven states. IDLE waits for start. IDLE goes to SETUP on start. In SETUP the response sine is formed and the divider is loaded. SETUP goes to SDIV, which waits for the divider and then goes to WSET. WSET latches the response value and loads the window division, then goes to WDIV. WDIV waits for the divider and then goes to EMIT. EMIT forms the weight and goes back to SETUP, or to DONE after the last tap. DONE returns to IDLE.

Top module: `fir_coef_gen`

## Requirements
- R1: After reset, including a reset applied in the middle of a run, busy, coef_valid and done are low, and no strobe appears until a new start.
- R2: An accepted start yields exactly N+1 coef_valid pulses, each one cycle long, with coef_idx running 0, 1, ..., N. done is high for one cycle, in the cycle after the last strobe, and busy is low in that cycle.
- R3: With win_sel = 0 (rectangular), each weight is within 100 LSB of 32768*sin(pi*fc*m)/(pi*m). Here fc = cutoff/65536 and m = n - N/2, and the result is clamped to the signed 16-bit range.
- R4: For even N with a rectangular window, the centre tap (n = N/2) is exactly floor(cutoff/2), the limit value fc in Q1.15.
- R5: With win_sel = 1 (triangular), each weight is within 100 LSB of 32768*h*(1 - |m|/(N+1)).
- R6: With win_sel = 2 (raised cosine), each weight is within 100 LSB of 32768*h*(0.54 + 0.46*cos(2*pi*m/(2N+1))).
- R7: win_sel = 3 gives the same weights as the rectangular window.
- R8: A start pulse while busy is high is ignored. The run in progress keeps its captured cutoff, order and window, and its tap count.
- R9: Successive coef_valid pulses within a run are exactly 69 cycles apart, which is 2*(DIV_NUM_W+1)+3 with the default 32-bit divider.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run; sampled only in IDLE |
| cutoff | input | 16 | Normalized cutoff fc as an unsigned fraction of 65536 |
| order | input | 6 | Filter order N; N+1 taps are produced |
| win_sel | input | 2 | Window: 0 rectangular, 1 triangular, 2 raised cosine, 3 rectangular |
| busy | output | 1 | High from the accepted start through the DONE state |
| coef_valid | output | 1 | One-cycle strobe per tap |
| coef_idx | output | 6 | Tap index of the current weight |
| coef | output | 16 | Signed Q1.15 weight |
| done | output | 1 | One-cycle pulse after the last tap |

## Verification
The bench targets several corner cases. For even orders it checks the centre tap, where a design without the limit substitute would divide by zero and return garbage instead of exactly fc. For large orders at high cutoff, the sinc angle wraps past pi several times, so a faulty fold would flip signs on outer taps. It fires a second start with other parameters in the middle of a run: a design that accepted it would change the tap count and the weights. It also checks the one-tap order-zero case, the unused window code, the exact tap cadence, and a reset in mid-run, where surviving state would let strobes leak out afterwards.

// File: rtl/fir_cg_pkg.sv
package fir_cg_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_SETUP,
        S_SDIV,
        S_WSET,
        S_WDIV,
        S_EMIT,
        S_DONE
    } cg_state_t;

    typedef enum logic [1:0] {
        WIN_RECT = 2'd0,
        WIN_TRI  = 2'd1,
        WIN_HAM  = 2'd2,
        WIN_ALT  = 2'd3
    } cg_win_t;

    // pi scaled by 2^13
    localparam int PI_Q13     = 25736;
    // 0.54 and 0.46 scaled by 2^15
    localparam int HAM_BASE   = 17695;
    localparam int HAM_SLOPE  = 15073;
    localparam int Q15_MAX    = 32767;

    function automatic logic signed [15:0] sat16(input logic signed [31:0] v);
        if (v > 32'sd32767)       return 16'sh7FFF;
        else if (v < -32'sd32768) return 16'sh8000;
        else                      return v[15:0];
    endfunction

endpackage

// File: rtl/fir_cg_sine.sv
module fir_cg_sine (
    input  logic signed [17:0] phase,
    output logic signed [15:0] sine
);
    // phase: angle in units of pi/2^17, taken modulo 2*pi; sine in Q2.14
    logic signed [18:0] red;
    logic signed [63:0] x, x2, p;

    always_comb begin
        red = 19'(phase);
        if (red > 19'sd65536)
            red = 19'sd131072 - red;
        else if (red < -19'sd65536)
            red = -19'sd131072 - red;
        x  = (64'(red) * 64'sd25736) >>> 16;
        x2 = x * x;
        p  = 64'sd2236962   - ((x2 * 64'sd53261) >>> 28);
        p  = 64'sd44739243  - ((x2 * p) >>> 28);
        p  = 64'sd268435456 - ((x2 * p) >>> 28);
        sine = 16'((x * p) >>> 28);
    end

endmodule

// File: rtl/fir_cg_divu.sv
module fir_cg_divu #(
    parameter int NUM_W = 32,
    parameter int DEN_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [NUM_W-1:0] num,
    input  logic [DEN_W-1:0] den,
    output logic [NUM_W-1:0] quo,
    output logic             fin
);
    localparam int CNT_W = $clog2(NUM_W + 1);
    localparam int PW    = NUM_W + DEN_W;

    logic [DEN_W-1:0] rem, den_r;
    logic [NUM_W-1:0] num_r;
    logic [CNT_W-1:0] cnt;
    logic [DEN_W:0]   shifted;

    assign shifted = {rem, quo[NUM_W-1]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem   <= '0;
            quo   <= '0;
            den_r <= '0;
            num_r <= '0;
            cnt   <= '0;
            fin   <= 1'b0;
        end else if (start) begin
            rem   <= '0;
            quo   <= num;
            num_r <= num;
            den_r <= den;
            cnt   <= CNT_W'(NUM_W);
            fin   <= 1'b0;
        end else if (cnt != '0) begin
            if (shifted >= {1'b0, den_r}) begin
                rem <= DEN_W'(shifted - {1'b0, den_r});
                quo <= {quo[NUM_W-2:0], 1'b1};
            end else begin
                rem <= shifted[DEN_W-1:0];
                quo <= {quo[NUM_W-2:0], 1'b0};
            end
            cnt <= cnt - 1'b1;
            fin <= (cnt == CNT_W'(1));
        end else begin
            fin <= 1'b0;
        end
    end

    // quotient and remainder reconstruct the dividend (R3, R5, R6)
    assert_div_exact_R3: assert property (@(posedge clk) disable iff (!rst_n)
        fin |-> ((PW'(quo) * PW'(den_r) + PW'(rem)) == PW'(num_r)) && (rem < den_r));

endmodule

// File: rtl/fir_coef_gen.sv
module fir_coef_gen
    import fir_cg_pkg::*;
#(
    parameter int CUT_W     = 16,
    parameter int ORD_W     = 6,
    parameter int DIV_NUM_W = 32,
    parameter int DIV_DEN_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CUT_W-1:0] cutoff,
    input  logic [ORD_W-1:0] order,
    input  logic [1:0]       win_sel,
    output logic             busy,
    output logic             coef_valid,
    output logic [ORD_W-1:0] coef_idx,
    output logic [15:0]      coef,
    output logic             done
);
    localparam int D_W     = ORD_W + 2;
    localparam int PRD_W   = CUT_W + D_W + 1;
    localparam int TAP_CYC = 2 * (DIV_NUM_W + 1) + 3;
    localparam int GAP_W   = $clog2(TAP_CYC + 2) + 1;

    cg_state_t state, nxt;

    logic [CUT_W-1:0]        fc_r;
    logic [ORD_W-1:0]        ord_r, n_r;
    cg_win_t                 win_r;
    logic                    sgn_r;
    logic signed [15:0]      h_r;

    logic signed [D_W-1:0]   d;
    logic [D_W-1:0]          d_abs;
    logic signed [PRD_W-1:0] ph_prod;
    logic signed [17:0]      ph_sinc, ph_cos, ph_in;
    logic signed [15:0]      sin_val;
    logic [15:0]             s_abs;

    logic                    div_start, div_fin;
    logic [DIV_NUM_W-1:0]    div_num, div_quo;
    logic [DIV_DEN_W-1:0]    div_den;

    logic [15:0]             h_mag, w15;
    logic signed [31:0]      w_tmp, mul;
    logic signed [15:0]      coef_nxt;

    // ---------------- offsets and phases ----------------
    assign d       = $signed({1'b0, n_r, 1'b0}) - $signed({2'b00, ord_r});
    assign d_abs   = d[D_W-1] ? D_W'(-d) : D_W'(d);
    assign ph_prod = $signed({1'b0, fc_r}) * d;
    assign ph_sinc = ph_prod[17:0];
    assign ph_cos  = $signed(18'(div_quo[16:0]) + 18'h10000);
    assign ph_in   = (state == S_EMIT) ? ph_cos : ph_sinc;
    assign s_abs   = sin_val[15] ? 16'(-sin_val) : 16'(sin_val);

    fir_cg_sine u_sine (
        .phase (ph_in),
        .sine  (sin_val)
    );

    fir_cg_divu #(
        .NUM_W (DIV_NUM_W),
        .DEN_W (DIV_DEN_W)
    ) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .start (div_start),
        .num   (div_num),
        .den   (div_den),
        .quo   (div_quo),
        .fin   (div_fin)
    );

    // ---------------- divider operand selection ----------------
    always_comb begin
        div_start = (state == S_SETUP) || (state == S_WSET);
        div_num   = '0;
        div_den   = DIV_DEN_W'(1);
        if (state == S_SETUP) begin
            div_num = DIV_NUM_W'(s_abs) << 15;
            if (d != '0)
                div_den = DIV_DEN_W'(d_abs) * DIV_DEN_W'(PI_Q13);
        end else if (state == S_WSET) begin
            unique case (win_r)
                WIN_TRI: begin
                    div_num = DIV_NUM_W'(d_abs) << 15;
                    div_den = DIV_DEN_W'({ord_r, 1'b0}) + DIV_DEN_W'(2);
                end
                WIN_HAM: begin
                    div_num = DIV_NUM_W'(d_abs) << 17;
                    div_den = DIV_DEN_W'({ord_r, 1'b0}) + DIV_DEN_W'(1);
                end
                WIN_RECT, WIN_ALT: begin
                    div_num = '0;
                    div_den = DIV_DEN_W'(1);
                end
            endcase
        end
    end

    // ---------------- window value and product ----------------
    assign h_mag = (div_quo > DIV_NUM_W'(Q15_MAX)) ? 16'(Q15_MAX) : div_quo[15:0];

    always_comb begin
        w_tmp = 32'sd32767;
        unique case (win_r)
            WIN_TRI:  w_tmp = 32'sd32768 - $signed(32'(div_quo[16:0]));
            WIN_HAM:  w_tmp = 32'(HAM_BASE) + ((32'(sin_val) * 32'(HAM_SLOPE)) >>> 14);
            WIN_RECT, WIN_ALT: w_tmp = 32'sd32767;
        endcase
        if (w_tmp > 32'sd32767)  w_tmp = 32'sd32767;
        else if (w_tmp < 32'sd0) w_tmp = 32'sd0;
        w15 = w_tmp[15:0];
        mul = h_r * $signed({1'b0, w15[14:0]});
        if (win_r == WIN_RECT || win_r == WIN_ALT)
            coef_nxt = h_r;
        else
            coef_nxt = sat16(mul >>> 15);
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:  if (start) nxt = S_SETUP;
            S_SETUP: nxt = S_SDIV;
            S_SDIV:  if (div_fin) nxt = S_WSET;
            S_WSET:  nxt = S_WDIV;
            S_WDIV:  if (div_fin) nxt = S_EMIT;
            S_EMIT:  nxt = (n_r == ord_r) ? S_DONE : S_SETUP;
            S_DONE:  nxt = S_IDLE;
            default: nxt = S_IDLE;
        endcase
    end

    // ---------------- run context ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fc_r  <= '0;
            ord_r <= '0;
            win_r <= WIN_RECT;
            n_r   <= '0;
            sgn_r <= 1'b0;
            h_r   <= '0;
        end else begin
            unique case (state)
                S_IDLE: if (start) begin
                    fc_r  <= cutoff;
                    ord_r <= order;
                    win_r <= cg_win_t'(win_sel);
                    n_r   <= '0;
                end
                S_SETUP: sgn_r <= sin_val[15] ^ d[D_W-1];
                S_WSET: begin
                    if (d == '0)
                        h_r <= $signed({1'b0, fc_r[CUT_W-1:CUT_W-15]});
                    else
                        h_r <= sgn_r ? $signed(16'(-h_mag)) : $signed(h_mag);
                end
                S_EMIT: if (n_r != ord_r) n_r <= n_r + 1'b1;
                S_SDIV, S_WDIV, S_DONE: ;
                default: ;
            endcase
        end
    end

    // ---------------- outputs ----------------
    assign busy = (state != S_IDLE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            coef_valid <= 1'b0;
            coef_idx   <= '0;
            coef       <= '0;
            done       <= 1'b0;
        end else begin
            coef_valid <= (state == S_EMIT);
            done       <= (state == S_DONE);
            if (state == S_EMIT) begin
                coef_idx <= n_r;
                coef     <= coef_nxt;
            end
        end
    end

    // ---------------- checks ----------------
    logic [GAP_W-1:0] gap_cnt;
    logic             had_tap;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_cnt <= '0;
            had_tap <= 1'b0;
        end else begin
            if (coef_valid)            gap_cnt <= GAP_W'(1);
            else if (gap_cnt != '1)    gap_cnt <= gap_cnt + 1'b1;
            if (done)                  had_tap <= 1'b0;
            else if (coef_valid)       had_tap <= 1'b1;
        end
    end

    assert_valid_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        coef_valid |=> !coef_valid);

    assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_valid_in_run_R2: assert property (@(posedge clk) disable iff (!rst_n)
        coef_valid |-> busy && !done);

    assert_start_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy && start |=> (fc_r == $past(fc_r)) && (ord_r == $past(ord_r)) && (win_r == $past(win_r)));

    assert_tap_cadence_R9: assert property (@(posedge clk) disable iff (!rst_n)
        coef_valid && had_tap |-> gap_cnt == GAP_W'(TAP_CYC));

endmodule

// File: tb/sim_fir_coef_gen.sv
module sim_fir_coef_gen;

    localparam real PI_R   = 3.14159265358979;
    localparam int  TOL    = 100;
    localparam int  GAP    = 2 * (32 + 1) + 3;
    localparam int  NVEC   = 7;

    // {cutoff, order, window}
    localparam logic [23:0] VEC [0:NVEC-1] = '{
        {16'h4000, 6'd20, 2'd0},
        {16'h8000, 6'd31, 2'd0},
        {16'h2000, 6'd40, 2'd1},
        {16'h6000, 6'd63, 2'd2},
        {16'h3000, 6'd15, 2'd2},
        {16'hF000, 6'd10, 2'd3},
        {16'hFFFF, 6'd0,  2'd0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] cutoff = '0;
    logic [5:0]  order = '0;
    logic [1:0]  win_sel = '0;
    logic        busy, coef_valid, done;
    logic [5:0]  coef_idx;
    logic [15:0] coef;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    fir_coef_gen u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .cutoff     (cutoff),
        .order      (order),
        .win_sel    (win_sel),
        .busy       (busy),
        .coef_valid (coef_valid),
        .coef_idx   (coef_idx),
        .coef       (coef),
        .done       (done)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int ideal(input int fcq, input int nn, input int win, input int n);
        real fc, m, h, w, c;
        fc = fcq / 65536.0;
        m  = n - nn / 2.0;
        if (m == 0.0) h = fc;
        else          h = $sin(PI_R * fc * m) / (PI_R * m);
        if (win == 1)      w = 1.0 - ((m < 0.0) ? -m : m) / (nn + 1.0);
        else if (win == 2) w = 0.54 + 0.46 * $cos(2.0 * PI_R * m / (2.0 * nn + 1.0));
        else               w = 1.0;
        c = h * w * 32768.0;
        if (c > 32767.0)  c = 32767.0;
        if (c < -32768.0) c = -32768.0;
        return $rtoi(c);
    endfunction

    function automatic string win_tag(input int win);
        if (win == 1)      return "R5";
        else if (win == 2) return "R6";
        else if (win == 3) return "R7";
        else               return "R3";
    endfunction

    task automatic run_vec(input int fcq, input int nn, input int win, input bit inject);
        int seen = 0;
        int cyc = 0;
        int last_v = -1;
        bit got_done = 1'b0;
        @(negedge clk);
        start = 1'b1; cutoff = 16'(fcq); order = 6'(nn); win_sel = 2'(win);
        @(negedge clk);
        start = 1'b0;
        while (!got_done && cyc < 8000) begin
            if (inject && cyc == 150) begin
                start = 1'b1; cutoff = 16'h1234; order = 6'd3; win_sel = 2'd2;
            end else if (inject && cyc == 151) begin
                start = 1'b0;
            end
            @(negedge clk);
            cyc++;
            if (coef_valid) begin
                int act, exp;
                chk(coef_idx == 6'(seen), inject ? "R8 index" : "R2 index", int'(coef_idx), seen);
                if (last_v >= 0)
                    chk(cyc - last_v == GAP, "R9 cadence", cyc - last_v, GAP);
                act = int'($signed(coef));
                exp = ideal(fcq, nn, win, seen);
                chk((act - exp <= TOL) && (exp - act <= TOL), inject ? "R8 weight" : win_tag(win), act, exp);
                if ((win == 0 || win == 3) && 2 * seen == nn)
                    chk(act == fcq / 2, "R4 centre", act, fcq / 2);
                last_v = cyc;
                seen++;
            end
            if (done) begin
                got_done = 1'b1;
                chk(seen == nn + 1, inject ? "R8 tap count" : "R2 tap count", seen, nn + 1);
                chk(cyc == last_v + 1, "R2 done timing", cyc, last_v + 1);
                chk(!busy, "R2 busy low at done", int'(busy), 0);
            end
        end
        if (!got_done) chk(1'b0, "R2 no done", cyc, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!busy && !coef_valid && !done, "R1 reset state", int'({busy, coef_valid, done}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !coef_valid && !done, "R1 idle after reset", int'({busy, coef_valid, done}), 0);

        for (int i = 0; i < NVEC; i++) begin
            run_vec(int'(VEC[i][23:8]), int'(VEC[i][7:2]), int'(VEC[i][1:0]), 1'b0);
        end

        // second start in the middle of a long run
        run_vec(16'h5000, 63, 1, 1'b1);

        // reset in the middle of a run
        @(negedge clk);
        start = 1'b1; cutoff = 16'h4000; order = 6'd30; win_sel = 2'd0;
        @(negedge clk);
        start = 1'b0;
        repeat (300) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(!busy && !coef_valid && !done, "R1 mid-run reset", int'({busy, coef_valid, done}), 0);
        rst_n = 1'b1;
        begin
            int leaks = 0;
            for (int k = 0; k < 200; k++) begin
                @(negedge clk);
                if (coef_valid || done || busy) leaks++;
            end
            chk(leaks == 0, "R1 quiet after reset", leaks, 0);
        end

        // run after reset recovery
        run_vec(16'h2800, 12, 0, 1'b0);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000 && !finished) begin
            finished = 1'b1;
            total++;
            bad++;
            $display("FAIL R2 watchdog expired actual=%0d expected=%0d", cycles, 150000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule